// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the register file of a colour LCD controller. A simple 32-bit bus reaches it through a 4 KB window that is word addressed. It stores four panel timing words, two frame base addresses (upper and lower panel), a control word and an interrupt mask. It also keeps a sticky raw interrupt status, which a test input sets and which a write to the clear register empties bit by bit. When a timing word is written, the block works out the active column and row counts of the panel from that word's fields. The enable condition and the pixel-depth field of the control word are sent to the rest of the controller.

A fixed 8-word identification area sits at the top of the window. A 128-word palette window is passed straight through to an external palette port. An input selects between two variants of the controller. The variants differ in the addresses of the control and mask registers and in their identification bytes. Any write that changes state raises a one-cycle invalidate pulse, which tells the display path to redraw.

Top module: `lcd_regif`

## Requirements
- R1: After reset every stored register, the column and row counts, `enable_o`, `depth_o`, `invalidate_o` and `rdata_o` are 0.
- R2: Words 0 to 3 hold 32-bit timing values that read back unchanged. A write to word 0 sets `cols_o` to ((value AND 0xFC) + 4) × 4.
- R3: A write to word 1 sets `rows_o` to (value AND 0x3FF) + 1. Writes to the other words leave `rows_o` unchanged.
- R4: Word 4 (upper base) and word 5 (lower base) read back as written. Word 11 reads the same value as word 4, and word 12 reads the same value as word 5.
- R5: With `variant_i` = 0, word 6 is the interrupt mask and word 7 is the control register. With `variant_i` = 1, the two words swap.
- R6: `enable_o` is 1 only when control bit 0 and control bit 11 are both 1. `depth_o` shows control bits [3:1].
- R7: Each 1 bit on `irq_set_i` sets the matching raw status bit, and the bit stays set. Word 8 reads the raw status in bits [4:0]. The mask keeps only bits [4:0] of a write. Word 9 reads raw AND mask.
- R8: A write to word 10 clears each raw bit that is written as 1. A set on `irq_set_i` in the same cycle wins over the clear. Word 10 reads as 0.
- R9: Words 0x3F8 to 0x3FF return one identification byte each. For variant 0 the bytes are 10,11,04,00,0D,F0,05,B1 (hex), in word order. For variant 1 the bytes are 11,11,24,00,0D,F0,05,B1.
- R10: Words 0x80 to 0xFF drive `pal_req_o` in the same cycle, and `pal_we_o` as well for a write. `pal_idx_o` is the word offset minus 0x80, and `pal_wdata_o` carries the write data. A read in this window returns `pal_rdata_i`.
- R11: Reads of any other word return 0. Writes to such a word, and writes to words 8, 9, 11, 12 and the identification words, change nothing.
- R12: `invalidate_o` is high for exactly the one cycle after a write to words 0 to 7, word 10 or the palette window. No other access raises it.
- R13: `rdata_o` shows the read data one cycle after a read request. It then holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| variant_i | input | 1 | Variant select (0 base, 1 later) |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 10 | Word address (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_set_i | input | 5 | Raw interrupt status set bits |
| pal_req_o | output | 1 | Palette access strobe |
| pal_we_o | output | 1 | Palette write strobe |
| pal_idx_o | output | 7 | Palette word index |
| pal_wdata_o | output | 32 | Palette write data |
| pal_rdata_i | input | 32 | Palette read data |
| cols_o | output | 11 | Active pixel columns |
| rows_o | output | 11 | Active pixel rows |
| enable_o | output | 1 | Display enabled |
| depth_o | output | 3 | Pixel-depth field |
| invalidate_o | output | 1 | One-cycle redraw pulse |

## Verification
A write takes effect at the clock edge that ends its request cycle. From that edge on, the stored registers, `cols_o`, `rows_o`, `enable_o`, `depth_o` and the raw status show the new value, and `invalidate_o` is high until the following edge. Read data arrives one edge after the request. The palette strobes, index and write data follow the bus inputs in the same cycle. The bench drives every input on the falling edge. It samples registered results at the next falling edge and samples the palette outputs shortly after it drives the inputs. Full sweeps over all 1024 word addresses in both variants check the decode, the read-back and the cases where a write must be ignored.

// File: rtl/lcd_regif_pkg.sv
package lcd_regif_pkg;

  localparam int unsigned N_TIM       = 4;
  localparam int unsigned TIM_IDX_W   = 2;
  localparam int unsigned ID_IDX_W    = 3;
  localparam int unsigned DEPTH_W     = 3;
  localparam int unsigned CTRL_EN     = 0;
  localparam int unsigned CTRL_PWR    = 11;
  localparam int unsigned CTRL_DEPTH  = 1;

  // word offsets inside the control area
  localparam logic [3:0] WO_UBASE = 4'd4;
  localparam logic [3:0] WO_LBASE = 4'd5;
  localparam logic [3:0] WO_SLOTA = 4'd6;
  localparam logic [3:0] WO_SLOTB = 4'd7;
  localparam logic [3:0] WO_RAW   = 4'd8;
  localparam logic [3:0] WO_MIS   = 4'd9;
  localparam logic [3:0] WO_CLR   = 4'd10;
  localparam logic [3:0] WO_UCUR  = 4'd11;
  localparam logic [3:0] WO_LCUR  = 4'd12;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_TIM,
    SEL_UBASE,
    SEL_LBASE,
    SEL_MASK,
    SEL_CTRL,
    SEL_RAW,
    SEL_MIS,
    SEL_CLR,
    SEL_UCUR,
    SEL_LCUR,
    SEL_ID,
    SEL_PAL
  } reg_sel_e;

  function automatic logic [7:0] id_byte(input logic later, input logic [ID_IDX_W-1:0] idx);
    case (idx)
      3'd0:    id_byte = later ? 8'h11 : 8'h10;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = later ? 8'h24 : 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  function automatic logic sel_writable(input reg_sel_e s);
    case (s)
      SEL_TIM, SEL_UBASE, SEL_LBASE, SEL_MASK,
      SEL_CTRL, SEL_CLR, SEL_PAL: sel_writable = 1'b1;
      default:                    sel_writable = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lcd_regif_decode.sv
module lcd_regif_decode
  import lcd_regif_pkg::*;
#(
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned PAL_IDX_W = 7,
  parameter logic [WORD_W-1:0] PAL_WORD_BASE = 'h080,
  parameter logic [WORD_W-1:0] ID_WORD_BASE  = 'h3F8
) (
  input  logic [WORD_W-1:0]    word_i,
  input  logic                 later_i,
  output reg_sel_e             sel_o,
  output logic [TIM_IDX_W-1:0] tim_idx_o,
  output logic [ID_IDX_W-1:0]  id_idx_o,
  output logic [PAL_IDX_W-1:0] pal_idx_o
);

  localparam int unsigned CTL_W = 4;

  logic in_id, in_pal, in_ctl;

  assign in_id  = word_i[WORD_W-1:ID_IDX_W]  == ID_WORD_BASE[WORD_W-1:ID_IDX_W];
  assign in_pal = word_i[WORD_W-1:PAL_IDX_W] == PAL_WORD_BASE[WORD_W-1:PAL_IDX_W];
  assign in_ctl = word_i[WORD_W-1:CTL_W] == '0;

  assign tim_idx_o = word_i[TIM_IDX_W-1:0];
  assign id_idx_o  = word_i[ID_IDX_W-1:0];
  assign pal_idx_o = word_i[PAL_IDX_W-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (in_id) begin
      sel_o = SEL_ID;
    end else if (in_pal) begin
      sel_o = SEL_PAL;
    end else if (in_ctl) begin
      case (word_i[CTL_W-1:0])
        4'd0, 4'd1, 4'd2, 4'd3: sel_o = SEL_TIM;
        WO_UBASE: sel_o = SEL_UBASE;
        WO_LBASE: sel_o = SEL_LBASE;
        WO_SLOTA: sel_o = later_i ? SEL_CTRL : SEL_MASK;
        WO_SLOTB: sel_o = later_i ? SEL_MASK : SEL_CTRL;
        WO_RAW:   sel_o = SEL_RAW;
        WO_MIS:   sel_o = SEL_MIS;
        WO_CLR:   sel_o = SEL_CLR;
        WO_UCUR:  sel_o = SEL_UCUR;
        WO_LCUR:  sel_o = SEL_LCUR;
        default:  sel_o = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/lcd_regif_geom.sv
module lcd_regif_geom #(
  parameter int unsigned DIM_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             col_we_i,
  input  logic [5:0]       col_fld_i,
  input  logic             row_we_i,
  input  logic [9:0]       row_fld_i,
  output logic [DIM_W-1:0] cols_o,
  output logic [DIM_W-1:0] rows_o
);

  localparam int unsigned COL_SH = 4; // 4 px per unit of the field, x4 scale

  logic [DIM_W-1:0] cols_d, rows_d;

  assign cols_d = (DIM_W'(col_fld_i) + DIM_W'(1)) << COL_SH;
  assign rows_d = DIM_W'(row_fld_i) + DIM_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cols_o <= '0;
      rows_o <= '0;
    end else begin
      if (col_we_i) cols_o <= cols_d;
      if (row_we_i) rows_o <= rows_d;
    end
  end

  assert_cols_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_we_i |=> $stable(cols_o));
  assert_cols_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_we_i |=> (cols_o != '0));
  assert_rows_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_we_i |=> $stable(rows_o));
  assert_rows_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_we_i |=> (rows_o != '0));

endmodule

// File: rtl/lcd_regif_irq.sv
module lcd_regif_irq #(
  parameter int unsigned INT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic             clr_we_i,
  input  logic [INT_W-1:0] wbits_i,
  input  logic [INT_W-1:0] set_i,
  output logic [INT_W-1:0] raw_o,
  output logic [INT_W-1:0] mask_o,
  output logic [INT_W-1:0] masked_o
);

  logic [INT_W-1:0] clr_bits;

  assign clr_bits = clr_we_i ? wbits_i : '0;
  assign masked_o = raw_o & mask_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o  <= '0;
      mask_o <= '0;
    end else begin
      raw_o <= (raw_o & ~clr_bits) | set_i; // set wins over clear
      if (mask_we_i) mask_o <= wbits_i;
    end
  end

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && set_i == '0) |=> ((raw_o & $past(wbits_i)) == '0));
  assert_set_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((raw_o & $past(set_i)) == $past(set_i)));
  assert_raw_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i && set_i == '0) |=> $stable(raw_o));

endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
  import lcd_regif_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WORD_W    = 10,
  parameter int unsigned INT_W     = 5,
  parameter int unsigned PAL_IDX_W = 7,
  parameter int unsigned DIM_W     = 11
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 variant_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [WORD_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [INT_W-1:0]     irq_set_i,
  output logic                 pal_req_o,
  output logic                 pal_we_o,
  output logic [PAL_IDX_W-1:0] pal_idx_o,
  output logic [DATA_W-1:0]    pal_wdata_o,
  input  logic [DATA_W-1:0]    pal_rdata_i,
  output logic [DIM_W-1:0]     cols_o,
  output logic [DIM_W-1:0]     rows_o,
  output logic                 enable_o,
  output logic [DEPTH_W-1:0]   depth_o,
  output logic                 invalidate_o
);

  reg_sel_e               sel;
  logic [TIM_IDX_W-1:0]   tim_idx;
  logic [ID_IDX_W-1:0]    id_idx;
  logic                   wr, rd;
  logic [DATA_W-1:0]      tim_q [N_TIM];
  logic [DATA_W-1:0]      ubase_q, lbase_q, ctrl_q;
  logic [INT_W-1:0]       raw, mask, masked;
  logic [DATA_W-1:0]      rd_val;
  logic                   ctrl_we;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  lcd_regif_decode #(
    .WORD_W   (WORD_W),
    .PAL_IDX_W(PAL_IDX_W)
  ) u_decode (
    .word_i   (addr_i),
    .later_i  (variant_i),
    .sel_o    (sel),
    .tim_idx_o(tim_idx),
    .id_idx_o (id_idx),
    .pal_idx_o(pal_idx_o)
  );

  // timing words
  for (genvar g = 0; g < N_TIM; g++) begin : g_tim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                                tim_q[g] <= '0;
      else if (wr && sel == SEL_TIM && tim_idx == TIM_IDX_W'(g)) tim_q[g] <= wdata_i;
    end
  end

  lcd_regif_geom #(.DIM_W(DIM_W)) u_geom (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .col_we_i (wr && sel == SEL_TIM && tim_idx == TIM_IDX_W'(0)),
    .col_fld_i(wdata_i[7:2]),
    .row_we_i (wr && sel == SEL_TIM && tim_idx == TIM_IDX_W'(1)),
    .row_fld_i(wdata_i[9:0]),
    .cols_o   (cols_o),
    .rows_o   (rows_o)
  );

  assign ctrl_we = wr && sel == SEL_CTRL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ubase_q <= '0;
      lbase_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr && sel == SEL_UBASE) ubase_q <= wdata_i;
      if (wr && sel == SEL_LBASE) lbase_q <= wdata_i;
      if (ctrl_we)                ctrl_q  <= wdata_i;
    end
  end

  assign enable_o = ctrl_q[CTRL_EN] & ctrl_q[CTRL_PWR];
  assign depth_o  = ctrl_q[CTRL_DEPTH +: DEPTH_W];

  lcd_regif_irq #(.INT_W(INT_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mask_we_i(wr && sel == SEL_MASK),
    .clr_we_i (wr && sel == SEL_CLR),
    .wbits_i  (wdata_i[INT_W-1:0]),
    .set_i    (irq_set_i),
    .raw_o    (raw),
    .mask_o   (mask),
    .masked_o (masked)
  );

  // palette pass-through
  assign pal_req_o   = req_i && sel == SEL_PAL;
  assign pal_we_o    = wr && sel == SEL_PAL;
  assign pal_wdata_o = wdata_i;

  always_comb begin
    case (sel)
      SEL_TIM:             rd_val = tim_q[tim_idx];
      SEL_UBASE, SEL_UCUR: rd_val = ubase_q;
      SEL_LBASE, SEL_LCUR: rd_val = lbase_q;
      SEL_CTRL:            rd_val = ctrl_q;
      SEL_MASK:            rd_val = {{(DATA_W-INT_W){1'b0}}, mask};
      SEL_RAW:             rd_val = {{(DATA_W-INT_W){1'b0}}, raw};
      SEL_MIS:             rd_val = {{(DATA_W-INT_W){1'b0}}, masked};
      SEL_ID:              rd_val = {{(DATA_W-8){1'b0}}, id_byte(variant_i, id_idx)};
      SEL_PAL:             rd_val = pal_rdata_i;
      default:             rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o      <= '0;
      invalidate_o <= 1'b0;
    end else begin
      if (rd) rdata_o <= rd_val;
      invalidate_o <= wr && sel_writable(sel);
    end
  end

  assert_rdata_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
  assert_inv_source_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalidate_o |-> $past(wr));
  assert_inv_on_read_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> !invalidate_o);
  assert_enable_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we |=> ($stable(enable_o) && $stable(depth_o)));
  assert_pal_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_we_o |-> (pal_req_o && we_i));

endmodule

// File: tb/lcd_regif_tb.sv
`timescale 1ns/1ps
module lcd_regif_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        variant = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  setv = '0;
  logic        pal_req, pal_we;
  logic [6:0]  pal_idx;
  logic [31:0] pal_wdata, pal_rdata;
  logic [10:0] cols, rows;
  logic        enable;
  logic [2:0]  depth;
  logic        inval;

  int checks = 0, errors = 0;

  // bench model
  logic [31:0] m_tim [4];
  logic [31:0] m_ub = 0, m_lb = 0, m_ctrl = 0;
  logic [4:0]  m_mask = 0, m_raw = 0;
  int          m_cols = 0, m_rows = 0;

  always #2.5 clk = ~clk;

  assign pal_rdata = 32'hA500_0000 | {25'd0, pal_idx};

  lcd_regif u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .variant_i(variant),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .irq_set_i(setv),
    .pal_req_o(pal_req), .pal_we_o(pal_we), .pal_idx_o(pal_idx),
    .pal_wdata_o(pal_wdata), .pal_rdata_i(pal_rdata),
    .cols_o(cols), .rows_o(rows), .enable_o(enable), .depth_o(depth),
    .invalidate_o(inval)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit writable(input int w);
    return (w <= 7) || (w == 10) || (w >= 128 && w <= 255);
  endfunction

  function automatic logic [7:0] exp_id(input bit v, input int i);
    case (i)
      0: return v ? 8'h11 : 8'h10;
      1: return 8'h11;
      2: return v ? 8'h24 : 8'h04;
      3: return 8'h00;
      4: return 8'h0D;
      5: return 8'hF0;
      6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input int w, input bit v);
    if (w <= 3) return m_tim[w];
    if (w == 4 || w == 11) return m_ub;
    if (w == 5 || w == 12) return m_lb;
    if (w == 6) return v ? m_ctrl : {27'd0, m_mask};
    if (w == 7) return v ? {27'd0, m_mask} : m_ctrl;
    if (w == 8) return {27'd0, m_raw};
    if (w == 9) return {27'd0, m_raw & m_mask};
    if (w >= 128 && w <= 255) return 32'hA500_0000 | (w - 128);
    if (w >= 1016) return {24'd0, exp_id(v, w - 1016)};
    return 32'd0;
  endfunction

  task automatic model_write(input int w, input logic [31:0] d, input logic [4:0] s);
    bit is_ctrl, is_mask;
    is_ctrl = (w == 7 && !variant) || (w == 6 && variant);
    is_mask = (w == 6 && !variant) || (w == 7 && variant);
    if (w <= 3) m_tim[w] = d;
    if (w == 0) m_cols = ((d & 32'hFC) + 4) * 4;
    if (w == 1) m_rows = (d & 32'h3FF) + 1;
    if (w == 4) m_ub = d;
    if (w == 5) m_lb = d;
    if (is_ctrl) m_ctrl = d;
    if (is_mask) m_mask = d[4:0];
    if (w == 10) m_raw = m_raw & ~d[4:0];
    m_raw = m_raw | s;
  endtask

  // write with optional same-cycle status set; checks invalidate (R12) and palette port (R10)
  task automatic bus_wr(input int w, input logic [31:0] d, input bit upd = 1'b1, input logic [4:0] s = 5'd0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = w[9:0]; wdata = d; setv = s;
    #1;
    if (w >= 128 && w <= 255)
      check(pal_req && pal_we && pal_idx == 7'(w - 128) && pal_wdata == d, "R10 palette write port",
            {pal_req, pal_we, 23'd0, pal_idx}, {2'b11, 23'd0, 7'(w - 128)});
    else
      check(!pal_req && !pal_we, "R10 no palette strobe", {30'd0, pal_req, pal_we}, 32'd0);
    @(negedge clk);
    req = 1'b0; we = 1'b0; setv = '0;
    if (upd) model_write(w, d, s);
    check(inval == (upd && writable(w)), "R12 invalidate pulse", {31'd0, inval}, {31'd0, upd && writable(w)});
    @(negedge clk);
    check(!inval, "R12 invalidate one cycle", {31'd0, inval}, 32'd0);
  endtask

  task automatic bus_rd(input int w, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = w[9:0];
    #1;
    if (w >= 128 && w <= 255)
      check(pal_req && !pal_we && pal_idx == 7'(w - 128), "R10 palette read strobe",
            {pal_req, pal_we, 23'd0, pal_idx}, {2'b10, 23'd0, 7'(w - 128)});
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input int w, input string tag);
    logic [31:0] d;
    bus_rd(w, d);
    check(d == exp_read(w, variant), tag, d, exp_read(w, variant));
  endtask

  task automatic sweep(input string tag);
    for (int w = 0; w < 1024; w++) rd_chk(w, tag);
  endtask

  task automatic pulse_set(input logic [4:0] s);
    @(negedge clk);
    setv = s;
    @(negedge clk);
    setv = '0;
    m_raw = m_raw | s;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] d, hold;
    for (int i = 0; i < 4; i++) m_tim[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cols == 0 && rows == 0, "R1 reset geometry", {cols, 5'd0, rows}, 32'd0);
    check(!enable && depth == 0 && !inval, "R1 reset enable/depth/invalidate",
          {27'd0, enable, depth, inval}, 32'd0);
    check(rdata == 0, "R1 reset rdata", rdata, 32'd0);
    sweep("R1 R9 R10 R11 reset read sweep v0");
    variant = 1'b1;
    sweep("R1 R9 R10 R11 reset read sweep v1");
    variant = 1'b0;

    // R2 column decode over every field value
    for (int k = 0; k < 64; k++) begin
      d = 32'hDEAD_BE00 | (k << 2) | 32'h3;
      bus_wr(0, d);
      check(int'(cols) == m_cols && m_cols == 16 * (k + 1), "R2 cols", {21'd0, cols}, m_cols);
      check(int'(rows) == m_rows, "R3 rows untouched by word 0", {21'd0, rows}, m_rows);
      rd_chk(0, "R2 timing0 readback");
    end

    // R3 row decode
    for (int k = 0; k < 40; k++) begin
      d = (k == 0) ? 32'h0 : (k == 1) ? 32'h3FF : (k == 2) ? 32'hFFFF_FC00 : (k * 32'h0123_4567);
      bus_wr(1, d);
      check(int'(rows) == m_rows, "R3 rows", {21'd0, rows}, m_rows);
      check(int'(cols) == m_cols, "R2 cols untouched by word 1", {21'd0, cols}, m_cols);
      rd_chk(1, "R3 timing1 readback");
    end
    bus_wr(2, 32'h1357_9BDF);
    bus_wr(3, 32'hFEDC_BA98);
    check(int'(rows) == m_rows && int'(cols) == m_cols, "R3 geometry untouched by words 2/3",
          {cols, 5'd0, rows}, {11'(m_cols), 5'd0, 11'(m_rows)});
    rd_chk(2, "R2 timing2 readback");
    rd_chk(3, "R2 timing3 readback");

    // R4 bases and current mirrors
    bus_wr(4, 32'h8000_1000);
    bus_wr(5, 32'h8004_2000);
    rd_chk(4, "R4 upper base");
    rd_chk(5, "R4 lower base");
    rd_chk(11, "R4 upper current");
    rd_chk(12, "R4 lower current");

    // R5/R6 base variant: word7 control, word6 mask
    for (int dp = 0; dp < 8; dp++) begin
      bus_wr(7, 32'h0000_0801 | (dp << 1));
      check(enable && depth == 3'(dp), "R6 enable/depth v0", {28'd0, enable, depth}, {28'd1, 3'(dp)});
    end
    bus_wr(7, 32'h0000_0001);
    check(!enable, "R6 enable needs power bit", {31'd0, enable}, 32'd0);
    bus_wr(7, 32'h0000_0800);
    check(!enable, "R6 enable needs enable bit", {31'd0, enable}, 32'd0);
    bus_wr(6, 32'hFFFF_FFF5);
    check(!enable, "R5 word6 is mask in v0", {31'd0, enable}, 32'd0);
    rd_chk(6, "R5 R7 mask readback v0");
    rd_chk(7, "R5 control readback v0");

    // R5/R6 later variant: swapped
    variant = 1'b1;
    rd_chk(6, "R5 word6 control v1");
    rd_chk(7, "R5 word7 mask v1");
    bus_wr(6, 32'h0000_080B);
    check(enable && depth == 3'd5, "R5 R6 control at word6 v1", {28'd0, enable, depth}, {28'd1, 3'd5});
    bus_wr(7, 32'h0000_0013);
    check(enable && depth == 3'd5, "R5 word7 not control v1", {28'd0, enable, depth}, {28'd1, 3'd5});
    rd_chk(7, "R5 mask at word7 v1");
    variant = 1'b0;
    rd_chk(7, "R5 control back at word7 v0");

    // R7/R8 interrupt status
    rd_chk(8, "R7 raw empty");
    pulse_set(5'b00101);
    rd_chk(8, "R7 raw set");
    rd_chk(9, "R7 masked");
    pulse_set(5'b11000);
    rd_chk(8, "R7 raw sticky");
    rd_chk(9, "R7 masked after second set");
    bus_wr(10, 32'h0000_0011);
    rd_chk(8, "R8 clear selected bits");
    rd_chk(10, "R8 clear word reads 0");
    bus_wr(10, 32'h0000_000C, 1'b1, 5'b00100);
    rd_chk(8, "R8 set wins over clear");
    for (int m = 0; m < 32; m++) begin
      bus_wr(6, m);
      rd_chk(9, "R7 masked sweep");
    end

    // R13 read hold
    rd_chk(4, "R13 read latency");
    hold = rdata;
    repeat (5) @(negedge clk);
    check(rdata == hold, "R13 hold while idle", rdata, hold);
    bus_wr(4, 32'h0BAD_F00D);
    check(rdata == hold, "R13 hold across write", rdata, hold);

    // R10 palette writes
    for (int w = 128; w < 256; w++) bus_wr(w, 32'h5A00_0000 + w);

    // R11 ignored writes
    for (int w = 8; w < 1024; w++)
      if (!writable(w)) bus_wr(w, 32'hFFFF_FFFF, 1'b0);
    sweep("R11 R9 R10 sweep after ignored writes v0");
    variant = 1'b1;
    sweep("R11 R9 R10 sweep after ignored writes v1");
    variant = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule